// File: doc/BRIEF.md
# Flag-Producing 16-bit Arithmetic and Logic Unit

This block is a purely combinational datapath unit for a small 16-bit processor core. A 3-bit operation select chooses one of eight functions: addition, subtraction, three bitwise operations, a move that passes the first operand through, and left and right shifts. Every function works on two 16-bit operands. The block returns a 16-bit result along with zero, negative and carry flags.

The surrounding core registers the flags, builds immediates and decodes instructions. The block helps it with a carry-update hint. That output tells the core whether the present operation should overwrite its stored carry flag. Zero and negative are meaningful for every operation, so the core may always take them. Carry changes only after arithmetic and shifts. After logic operations and the move, the core keeps its old carry.

Top module: `alu16_core`

## Requirements
- R1: Operation code 000 (add) returns A + B modulo 2^16, and the carry flag is the carry out of bit 15.
- R2: Operation code 001 (subtract) returns A - B modulo 2^16, and the carry flag is 1 exactly when A < B as unsigned numbers (a borrow).
- R3: Operation codes 010, 011 and 100 return the bitwise AND, OR and XOR of A and B respectively, and the carry flag output is 0.
- R4: Operation code 101 (move) returns A unchanged, whatever the value of B, and the carry flag output is 0.
- R5: Operation code 110 shifts A left by B[3:0] places with zeros entering bit 0. B[15:4] has no effect. The carry flag is the last bit moved out of bit 15.
- R6: Operation code 111 shifts A right logically by B[3:0] places with zeros entering bit 15. B[15:4] has no effect. The carry flag is the last bit moved out of bit 0.
- R7: For either shift with B[3:0] = 0, the result equals A and the carry flag is 0.
- R8: The zero flag is 1 exactly when the 16-bit result is 0, for every operation code.
- R9: The negative flag equals result bit 15, for every operation code.
- R10: The carry-update output is 1 for operation codes 000, 001, 110 and 111 and 0 for codes 010 to 101. The carry flag output is 0 whenever the carry-update output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation select code |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand; its low 4 bits are the shift distance |
| result | output | 16 | Operation result |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 15 |
| flag_c | output | 1 | Carry or borrow from the current operation |
| carry_upd | output | 1 | Core should overwrite its carry flag |

## Verification
The immediate assertions assume that the three select bits and both operands are driven with known 0/1 values whenever they are evaluated. They also assume that any transient mix of old and new input values has settled before the values are compared. The bench drives every input from a task at a clock edge, never leaves an input undriven, and reads the outputs a few nanoseconds later. The assertions therefore only ever see settled, fully defined values. The random sweep draws every operand bit from a uniform source, so the upper bits of B vary freely during shifts. This exercises the rule that those bits are ignored.

// File: rtl/alu16_pkg.sv
// Package for the 16-bit ALU: operation encoding and helper functions.
// Assumes a fixed 3-bit operation code shared with the instruction decoder.
package alu16_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_MOV = 3'b101,
        OP_SHL = 3'b110,
        OP_SHR = 3'b111
    } alu_op_e;

    // True for operations whose carry result the core must keep
    function automatic logic writes_carry(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SHL) || (op == OP_SHR);
    endfunction

endpackage

// File: rtl/alu16_addsub.sv
// Adder/subtractor for the ALU.
// Produces A+B or A-B. carry_o is the carry out on add and the unsigned borrow on subtract.
// Assumes the operands are unsigned bit vectors; signed overflow is not reported.
module alu16_addsub #(
    parameter int WIDTH = 16
) (
    input  logic             sub_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o
);

    logic [WIDTH:0] wide_add;
    logic [WIDTH:0] wide_sub;

    // Form both widened results; bit WIDTH holds the carry or the borrow
    always_comb begin
        wide_add = {1'b0, a_i} + {1'b0, b_i};
        wide_sub = {1'b0, a_i} - {1'b0, b_i};
    end

    // Pick the result for the requested direction
    always_comb begin
        if (sub_i) begin
            sum_o   = wide_sub[WIDTH-1:0];
            carry_o = wide_sub[WIDTH];
        end else begin
            sum_o   = wide_add[WIDTH-1:0];
            carry_o = wide_add[WIDTH];
        end
    end

    // R2: a borrow flag means the unsigned minuend was the smaller value
    always_comb begin
        if (sub_i) begin
            a_r2_borrow_order: assert (carry_o == (a_i < b_i))
                else $error("a_r2_borrow_order: borrow disagrees with operand order");
        end
    end

endmodule

// File: rtl/alu16_shifter.sv
// One-direction logical barrel shifter for the ALU.
// LEFT picks the direction. carry_o is the last bit pushed out; a zero distance gives carry 0.
// Assumes the distance is already cut to SHAMT_W bits by the caller.
module alu16_shifter #(
    parameter int WIDTH   = 16,
    parameter bit LEFT    = 1'b1,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   a_i,
    input  logic [SHAMT_W-1:0] shamt_i,
    output logic [WIDTH-1:0]   res_o,
    output logic               carry_o
);

    logic [WIDTH:0] ext;

    generate
        if (LEFT) begin : g_left
            // Shift left with a spare bit above the top to catch the last bit out
            always_comb begin
                ext     = {1'b0, a_i} << shamt_i;
                res_o   = ext[WIDTH-1:0];
                carry_o = ext[WIDTH];
            end
        end else begin : g_right
            // Shift right with a spare bit below the bottom to catch the last bit out
            always_comb begin
                ext     = {a_i, 1'b0} >> shamt_i;
                res_o   = ext[WIDTH:1];
                carry_o = ext[0];
            end
        end
    endgenerate

    // R7: a zero distance passes the operand through and produces no carry
    always_comb begin
        if (shamt_i == '0) begin
            a_r7_zero_shift: assert (res_o == a_i && carry_o == 1'b0)
                else $error("a_r7_zero_shift: zero-distance shift altered data");
        end
    end

endmodule

// File: rtl/alu16_logic.sv
// Bitwise and move unit for the ALU.
// Handles AND, OR, XOR and the move of operand A; other codes return zero.
// Assumes the caller selects this output only for those four codes.
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  alu_op_e          op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o
);

    // Apply the bitwise function named by the code
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_MOV:  res_o = a_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu16_core.sv
// Top of the flag-producing ALU.
// Combines the add/sub, shift and logic units, selects the result by operation code
// and derives the zero, negative and carry flags plus the carry-update hint.
// Assumes purely combinational use; the core registers the flags as it needs.
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             carry_upd
);

    localparam int SHAMT_W = $clog2(WIDTH);

    alu_op_e            op;
    logic [SHAMT_W-1:0] shamt;
    logic [WIDTH-1:0]   as_res, shl_res, shr_res, lg_res;
    logic               as_c, shl_c, shr_c;

    assign op    = alu_op_e'(op_sel);
    assign shamt = opnd_b[SHAMT_W-1:0];

    alu16_addsub #(.WIDTH(WIDTH)) u_addsub (
        .sub_i   (op == OP_SUB),
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .sum_o   (as_res),
        .carry_o (as_c)
    );

    alu16_shifter #(.WIDTH(WIDTH), .LEFT(1'b1), .SHAMT_W(SHAMT_W)) u_shl (
        .a_i     (opnd_a),
        .shamt_i (shamt),
        .res_o   (shl_res),
        .carry_o (shl_c)
    );

    alu16_shifter #(.WIDTH(WIDTH), .LEFT(1'b0), .SHAMT_W(SHAMT_W)) u_shr (
        .a_i     (opnd_a),
        .shamt_i (shamt),
        .res_o   (shr_res),
        .carry_o (shr_c)
    );

    alu16_logic #(.WIDTH(WIDTH)) u_logic (
        .op_i  (op),
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .res_o (lg_res)
    );

    // Choose the result and the raw carry for the selected operation
    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: begin result = as_res;  flag_c = as_c;  end
            OP_SHL:         begin result = shl_res; flag_c = shl_c; end
            OP_SHR:         begin result = shr_res; flag_c = shr_c; end
            default:        begin result = lg_res;  flag_c = 1'b0;  end
        endcase
    end

    // Derive the status flags and the carry-update hint
    always_comb begin
        flag_z    = (result == '0);
        flag_n    = result[WIDTH-1];
        carry_upd = writes_carry(op);
    end

    // Cross-checks between the sub-units and the output flags
    always_comb begin
        // R4: move ignores B entirely
        if (op == OP_MOV) begin
            a_r4_mov_pass: assert (result == opnd_a)
                else $error("a_r4_mov_pass: move did not return operand A");
        end
        // R10: no carry is reported when the core must keep its old one
        if (!carry_upd) begin
            a_r10_carry_quiet: assert (flag_c == 1'b0)
                else $error("a_r10_carry_quiet: carry raised without update");
        end
        // R6: a non-zero logical right shift always clears the top bit
        if (op == OP_SHR && shamt != '0) begin
            a_r6_top_clear: assert (result[WIDTH-1] == 1'b0)
                else $error("a_r6_top_clear: right shift did not zero-fill");
        end
        // R1: adding zero leaves A unchanged with no carry
        if (op == OP_ADD && opnd_b == '0) begin
            a_r1_add_zero: assert (result == opnd_a && !flag_c)
                else $error("a_r1_add_zero: adding zero changed data");
        end
        // R8, R9: a zero result cannot be negative
        if (flag_z) begin
            a_r8_zero_not_neg: assert (!flag_n)
                else $error("a_r8_zero_not_neg: zero and negative both set");
        end
    end

endmodule

// File: tb/test_alu16_core.sv
// Directed and random bench for alu16_core; each task checks its own scenario.
module test_alu16_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  op_sel;
    logic [15:0] opnd_a, opnd_b;
    logic [15:0] result;
    logic        flag_z, flag_n, flag_c, carry_upd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu16_core i_alu16_core (
        .op_sel    (op_sel),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .flag_z    (flag_z),
        .flag_n    (flag_n),
        .flag_c    (flag_c),
        .carry_upd (carry_upd)
    );

    // Independent reference: shifts done one step at a time
    task automatic model(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] r, output logic c, output logic u);
        logic [15:0] t;
        int unsigned s;
        r = 16'h0; c = 1'b0; u = 1'b0;
        s = b & 16'h000F;
        case (op)
            3'd0: begin r = a + b; c = (32'(a) + 32'(b)) > 32'hFFFF; u = 1'b1; end
            3'd1: begin r = a - b; c = (a < b); u = 1'b1; end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = a;
            3'd6: begin
                t = a;
                for (int k = 0; k < int'(s); k++) begin c = t[15]; t = {t[14:0], 1'b0}; end
                r = t; u = 1'b1;
            end
            default: begin
                t = a;
                for (int k = 0; k < int'(s); k++) begin c = t[0]; t = {1'b0, t[15:1]}; end
                r = t; u = 1'b1;
            end
        endcase
    endtask

    // Drive one vector, wait for settling, compare every output against the model
    task automatic run_one(input string req, input logic [2:0] op,
                           input logic [15:0] a, input logic [15:0] b);
        logic [15:0] er;
        logic ec, eu;
        @(posedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        #2;
        model(op, a, b, er, ec, eu);
        n_checks++;
        if (result !== er || flag_z !== (er == 16'h0) || flag_n !== er[15] ||
            flag_c !== ec || carry_upd !== eu) begin
            n_fail++;
            $display("FAIL %s op=%0d a=%h b=%h: got r=%h z=%b n=%b c=%b u=%b, exp r=%h z=%b n=%b c=%b u=%b",
                     req, op, a, b, result, flag_z, flag_n, flag_c, carry_upd,
                     er, (er == 16'h0), er[15], ec, eu);
        end
    endtask

    task automatic t_idle_state;   // R8 R1: all-zero inputs give a zero add
        run_one("R8", 3'd0, 16'h0000, 16'h0000);
    endtask

    task automatic t_add;          // R1 R9
        run_one("R1", 3'd0, 16'hFFFF, 16'h0001);
        run_one("R1", 3'd0, 16'h7FFF, 16'h0001);
        run_one("R9", 3'd0, 16'h8000, 16'h8000);
        run_one("R1", 3'd0, 16'h1234, 16'h4321);
    endtask

    task automatic t_sub;          // R2
        run_one("R2", 3'd1, 16'h0005, 16'h0005);
        run_one("R2", 3'd1, 16'h0000, 16'h0001);
        run_one("R2", 3'd1, 16'h8000, 16'h7FFF);
    endtask

    task automatic t_logic;        // R3 R10
        run_one("R3", 3'd2, 16'hF0F0, 16'h0FF0);
        run_one("R3", 3'd3, 16'hF000, 16'h000F);
        run_one("R3", 3'd4, 16'hAAAA, 16'hAAAA);
        run_one("R10", 3'd4, 16'hFFFF, 16'h0001);
    endtask

    task automatic t_mov;          // R4
        run_one("R4", 3'd5, 16'h8001, 16'hFFFF);
        run_one("R4", 3'd5, 16'h0000, 16'h1234);
    endtask

    task automatic t_shift;        // R5 R6 R7
        run_one("R5", 3'd6, 16'h8001, 16'h0001);
        run_one("R5", 3'd6, 16'h0001, 16'hFFF0 | 16'h000F);
        run_one("R5", 3'd6, 16'h4000, 16'h1232);
        run_one("R6", 3'd7, 16'h8001, 16'h0001);
        run_one("R6", 3'd7, 16'h8000, 16'hABCF);
        run_one("R6", 3'd7, 16'h0003, 16'h0002);
        run_one("R7", 3'd6, 16'hFFFF, 16'hFFF0);
        run_one("R7", 3'd7, 16'hFFFF, 16'h0010);
    endtask

    task automatic t_random;       // R1..R10 sweep, each op in turn
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] op;
            op = 3'(i % 8);
            run_one(op == 3'd0 ? "R1" : op == 3'd1 ? "R2" : op == 3'd5 ? "R4" :
                    op == 3'd6 ? "R5" : op == 3'd7 ? "R6" : "R3",
                    op, 16'($urandom), 16'($urandom));
        end
    endtask

    initial begin
        op_sel = 3'd0; opnd_a = 16'h0; opnd_b = 16'h0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle_state();
        t_add();
        t_sub();
        t_logic();
        t_mov();
        t_shift();
        t_random();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog: ends a hung run as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule